// File: doc/BRIEF.md
# Dual-Channel DAC Register Readback Controller

This block holds the register state of a two-channel, 12-bit DAC and answers reads from a two-wire serial host. A bit-level front end, outside this block, decodes the bus and delivers one-cycle events: a START or repeated START together with the transfer direction, a STOP, a received byte, a request for the next byte to transmit, and a NACK from the host. Writes are three bytes long: a command byte and two data bytes. The command's upper nibble is the operation and its lower nibble is the channel select. Each channel has a staging code register, an output register and a power-down flag. There is also a two-bit reference field, a reference-mode bit and a fixed revision number.

Two kinds of read are supported. If the last write stopped after its command byte, the read returns a 16-bit word selected by that command, high byte first. If the last write completed all three bytes, that write was executed and the read returns the three bytes it carried. Read bytes requested beyond the defined ones return 0xFF.

A sequencer walks through the states ST_IDLE, ST_WCMD, ST_WHI, ST_WLO, ST_WSKIP, ST_RSEND and ST_RDONE:
- A START with write direction enters ST_WCMD from any state.
- A START with read direction enters ST_RSEND from any state.
- A STOP returns the sequencer to ST_IDLE.
- In a write, each received byte advances the sequencer: ST_WCMD to ST_WHI, ST_WHI to ST_WLO, and ST_WLO to ST_WSKIP. The step out of ST_WLO executes the command.
- ST_WSKIP discards any further bytes.
- A host NACK moves ST_RSEND to ST_RDONE.

Top module: `dac_rb_ctrl`

## Requirements
- R1: After reset, `dac_a`, `dac_b` and `pwdn` are 0. A read issued before any write returns 0x00 and then 0x30, which is the identification word with the reference field and the mode bit both at 0.
- R2: A completed write with operation 0x8 sets the code register from the 12 most significant bits of {data1, data2}. The select value picks the target: 0x0 writes channel A, 0x1 writes channel B, 0xF writes both, and any other value writes neither. `dac_a` and `dac_b` do not change.
- R3: A completed write with operation 0x1, 0x2 or 0x3 copies the code register into the output register of each selected channel (same select decoding as R2). The data bytes are ignored.
- R4: After a write that sends only a command byte, a read returns a 16-bit word: the code value in bits [15:4] and zeros in bits [3:0]. Operation 0x8 returns the code register and operations 0x1 to 0x3 return the output register. Select 0x1 reads channel B; every other select reads channel A.
- R5: A completed write with operation 0x4 loads `pwdn` from data2[1:0], where bit 0 is channel A and bit 1 is channel B, and 1 means powered down. A command-only read with operation 0x4 returns 0x00 and then {6'b0, pwdn}.
- R6: A completed write with operation 0x7 sets the reference field from data2[1:0] and the mode bit from data2[2]. A command-only read with any operation other than 0x1, 0x2, 0x3, 0x4 or 0x8 returns 0x00 and then a byte holding 0 in bit 7, 3'b011 in bits [6:4], 0 in bit 3, the mode bit in bit 2 and the reference field in bits [1:0].
- R7: After a completed write, a read returns the command byte, then data1, then data2. This holds whether the read follows a repeated START or a STOP and a new START. The echo continues on later reads until a new command byte is received.
- R8: A write that ends after one or two bytes executes nothing and does not enable the echo. A following read gives the R4/R5/R6 word for that write's command byte.
- R9: In a read, bytes requested after the last defined byte return 0xFF: after the third byte in echo mode, after the second otherwise. After a host NACK, every further byte requested in that transfer returns 0xFF.
- R10: Bytes received after the third byte of a write change no register and do not change the echoed bytes.
- R11: `rd_valid` is high for exactly the one cycle after each `rd_req` cycle, and `rd_data` holds the byte during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | START or repeated START event |
| ev_rnw | input | 1 | Direction sampled with `ev_start`, 1 = read |
| ev_stop | input | 1 | STOP event |
| rx_valid | input | 1 | A write byte has been received |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next byte to transmit |
| rd_nack | input | 1 | Host did not acknowledge the last byte |
| rd_data | output | 8 | Byte to transmit |
| rd_valid | output | 1 | `rd_data` valid, one cycle after `rd_req` |
| dac_a | output | CODE_W | Channel A output register |
| dac_b | output | CODE_W | Channel B output register |
| pwdn | output | 2 | Power-down flags, bit 0 = channel A |

## Verification
The assertions check on every cycle that:
- `rd_valid` follows `rd_req` by exactly one cycle;
- the output registers and power flags change only after a received byte;
- a byte requested past the defined bytes, or after a NACK, is 0xFF.

Only the bench scenarios can show which word a read returns. That depends on the whole history of transfers: whether the last write was completed or cut short, which operation and select it carried, and whether a repeated START or a STOP came between the write and the read. The bench therefore sweeps selects, operations, codes and power patterns against its own model.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WCMD,
        ST_WHI,
        ST_WLO,
        ST_WSKIP,
        ST_RSEND,
        ST_RDONE
    } rb_state_t;

    localparam logic [3:0] OP_PWR  = 4'h4;
    localparam logic [3:0] OP_REF  = 4'h7;
    localparam logic [3:0] OP_CODE = 4'h8;
    localparam logic [3:0] SEL_ALL = 4'hF;

    function automatic logic is_load(input logic [3:0] op);
        return (op == 4'h1) || (op == 4'h2) || (op == 4'h3);
    endfunction

endpackage

// File: rtl/dac_rb_seq.sv
module dac_rb_seq
    import dac_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_rnw,
    input  logic              ev_stop,
    input  logic              rx_valid,
    input  logic              rd_req,
    input  logic              rd_nack,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              st_cmd,
    output logic              st_hi,
    output logic              st_exec,
    output logic [1:0]        rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output rb_state_t         state
);

    rb_state_t state_nx;
    logic      quiet;

    assign quiet = !ev_start && !ev_stop;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        st_cmd   = 1'b0;
        st_hi    = 1'b0;
        st_exec  = 1'b0;
        if (ev_start) begin
            state_nx = ev_rnw ? ST_RSEND : ST_WCMD;
        end else if (ev_stop) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_WCMD:  if (rx_valid) begin state_nx = ST_WHI;   st_cmd  = 1'b1; end
                ST_WHI:   if (rx_valid) begin state_nx = ST_WLO;   st_hi   = 1'b1; end
                ST_WLO:   if (rx_valid) begin state_nx = ST_WSKIP; st_exec = 1'b1; end
                ST_RSEND: if (rd_nack)    state_nx = ST_RDONE;
                ST_IDLE, ST_WSKIP, ST_RDONE: state_nx = state;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx   <= '0;
            rd_data  <= '1;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= (state == ST_RSEND) ? tx_byte : '1;
            if (ev_start)
                rd_idx <= '0;
            else if (quiet && rd_req && state == ST_RSEND && rd_idx != 2'd3)
                rd_idx <= rd_idx + 2'd1;
        end
    end

endmodule

// File: rtl/dac_rb_regs.sv
module dac_rb_regs
    import dac_rb_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_cmd,
    input  logic                   st_hi,
    input  logic                   st_exec,
    input  logic [BYTE_W-1:0]      rx_byte,
    output logic [BYTE_W-1:0]      cmd_q,
    output logic [BYTE_W-1:0]      hi_q,
    output logic [BYTE_W-1:0]      lo_q,
    output logic                   armed,
    output logic [1:0][CODE_W-1:0] code_q,
    output logic [1:0][CODE_W-1:0] dac_q,
    output logic [1:0]             pwdn,
    output logic [1:0]             ref_rf,
    output logic                   ref_mode
);

    localparam int WORD_W = 2 * BYTE_W;

    logic [3:0]        op;
    logic [3:0]        sel;
    logic [WORD_W-1:0] in_word;
    logic [CODE_W-1:0] in_code;

    assign op      = cmd_q[7:4];
    assign sel     = cmd_q[3:0];
    assign in_word = {hi_q, rx_byte};
    assign in_code = in_word[WORD_W-1 -: CODE_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            hi_q     <= '0;
            lo_q     <= '0;
            armed    <= 1'b0;
            pwdn     <= '0;
            ref_rf   <= '0;
            ref_mode <= 1'b0;
        end else begin
            if (st_cmd) begin
                cmd_q <= rx_byte;
                armed <= 1'b0;
            end
            if (st_hi) hi_q <= rx_byte;
            if (st_exec) begin
                lo_q  <= rx_byte;
                armed <= 1'b1;
                if (op == OP_PWR) pwdn <= rx_byte[1:0];
                if (op == OP_REF) begin
                    ref_rf   <= rx_byte[1:0];
                    ref_mode <= rx_byte[2];
                end
            end
        end
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        logic hit;
        assign hit = (sel == 4'(ch)) || (sel == SEL_ALL);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[ch] <= '0;
                dac_q[ch]  <= '0;
            end else if (st_exec && hit) begin
                if (op == OP_CODE) code_q[ch] <= in_code;
                if (is_load(op))   dac_q[ch]  <= code_q[ch];
            end
        end
    end

endmodule

// File: rtl/dac_rb_rdmux.sv
module dac_rb_rdmux
    import dac_rb_pkg::*;
#(
    parameter int         CODE_W = 12,
    parameter logic [2:0] REV_ID = 3'b011
) (
    input  logic [BYTE_W-1:0]      cmd_q,
    input  logic [BYTE_W-1:0]      hi_q,
    input  logic [BYTE_W-1:0]      lo_q,
    input  logic                   armed,
    input  logic [1:0][CODE_W-1:0] code_q,
    input  logic [1:0][CODE_W-1:0] dac_q,
    input  logic [1:0]             pwdn,
    input  logic [1:0]             ref_rf,
    input  logic                   ref_mode,
    input  logic [1:0]             rd_idx,
    output logic [BYTE_W-1:0]      tx_byte
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam int PAD_W  = WORD_W - CODE_W;

    logic [3:0]        op;
    logic              ch;
    logic [WORD_W-1:0] word;

    assign op = cmd_q[7:4];
    assign ch = (cmd_q[3:0] == 4'h1);

    always_comb begin
        if (op == OP_CODE)
            word = WORD_W'(code_q[ch]) << PAD_W;
        else if (is_load(op))
            word = WORD_W'(dac_q[ch]) << PAD_W;
        else if (op == OP_PWR)
            word = {{(WORD_W-2){1'b0}}, pwdn};
        else
            word = {{BYTE_W{1'b0}}, 1'b0, REV_ID, 1'b0, ref_mode, ref_rf};
    end

    always_comb begin
        tx_byte = '1;
        if (armed) begin
            unique case (rd_idx)
                2'd0:    tx_byte = cmd_q;
                2'd1:    tx_byte = hi_q;
                2'd2:    tx_byte = lo_q;
                default: tx_byte = '1;
            endcase
        end else begin
            unique case (rd_idx)
                2'd0:    tx_byte = word[WORD_W-1:BYTE_W];
                2'd1:    tx_byte = word[BYTE_W-1:0];
                default: tx_byte = '1;
            endcase
        end
    end

endmodule

// File: rtl/dac_rb_ctrl.sv
module dac_rb_ctrl
    import dac_rb_pkg::*;
#(
    parameter int         CODE_W = 12,
    parameter logic [2:0] REV_ID = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_rnw,
    input  logic              ev_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rd_req,
    input  logic              rd_nack,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b,
    output logic [1:0]        pwdn
);

    logic                   st_cmd, st_hi, st_exec;
    logic [1:0]             rd_idx;
    logic [BYTE_W-1:0]      tx_byte;
    logic [BYTE_W-1:0]      cmd_q, hi_q, lo_q;
    logic                   armed;
    logic [1:0][CODE_W-1:0] code_q, dac_q;
    logic [1:0]             ref_rf;
    logic                   ref_mode;
    rb_state_t              state;

    dac_rb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rnw(ev_rnw),
        .ev_stop(ev_stop), .rx_valid(rx_valid), .rd_req(rd_req),
        .rd_nack(rd_nack), .tx_byte(tx_byte), .st_cmd(st_cmd),
        .st_hi(st_hi), .st_exec(st_exec), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_valid(rd_valid), .state(state)
    );

    dac_rb_regs #(.CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .st_cmd(st_cmd), .st_hi(st_hi),
        .st_exec(st_exec), .rx_byte(rx_byte), .cmd_q(cmd_q), .hi_q(hi_q),
        .lo_q(lo_q), .armed(armed), .code_q(code_q), .dac_q(dac_q),
        .pwdn(pwdn), .ref_rf(ref_rf), .ref_mode(ref_mode)
    );

    dac_rb_rdmux #(.CODE_W(CODE_W), .REV_ID(REV_ID)) u_mux (
        .cmd_q(cmd_q), .hi_q(hi_q), .lo_q(lo_q), .armed(armed),
        .code_q(code_q), .dac_q(dac_q), .pwdn(pwdn), .ref_rf(ref_rf),
        .ref_mode(ref_mode), .rd_idx(rd_idx), .tx_byte(tx_byte)
    );

    assign dac_a = dac_q[0];
    assign dac_b = dac_q[1];

endmodule

// File: rtl/dac_rb_checker.sv
module dac_rb_checker
    import dac_rb_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic [CODE_W-1:0] dac_a,
    input logic [CODE_W-1:0] dac_b,
    input logic [1:0]        pwdn,
    input logic [1:0]        rd_idx,
    input rb_state_t         state
);

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);  // R11
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));  // R11
    AST_DAC_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_a) || !$stable(dac_b)) |-> $past(rx_valid));  // R3
    AST_PWDN_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwdn) |-> $past(rx_valid));  // R5
    AST_TAIL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state == ST_RSEND && rd_idx == 2'd3) |=> rd_data == 8'hFF);  // R9
    AST_NACK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state == ST_RDONE) |=> rd_data == 8'hFF);  // R9

endmodule

bind dac_rb_ctrl dac_rb_checker #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .dac_a(dac_a), .dac_b(dac_b),
    .pwdn(pwdn), .rd_idx(rd_idx), .state(state)
);

// File: tb/dac_rb_ctrl_test.sv
module dac_rb_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_start = 1'b0, ev_rnw = 1'b0, ev_stop = 1'b0;
    logic        rx_valid = 1'b0, rd_req = 1'b0, rd_nack = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [11:0] dac_a, dac_b;
    logic [1:0]  pwdn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] m_code [2];
    logic [11:0] m_dac  [2];
    logic [1:0]  m_pd = '0, m_rf = '0;
    logic        m_mode = 1'b0, m_armed = 1'b0;
    logic [7:0]  m_cmd = '0;
    logic [23:0] m_echo = '0;

    always #10 clk = ~clk;

    dac_rb_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rnw(ev_rnw),
        .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_req(rd_req), .rd_nack(rd_nack), .rd_data(rd_data),
        .rd_valid(rd_valid), .dac_a(dac_a), .dac_b(dac_b), .pwdn(pwdn)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic rnw);
        @(negedge clk); ev_start = 1'b1; ev_rnw = rnw;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic get_byte(output logic [7:0] b, output logic v);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        b = rd_data; v = rd_valid;
    endtask

    task automatic send_nack();
        @(negedge clk); rd_nack = 1'b1;
        @(negedge clk); rd_nack = 1'b0;
    endtask

    function automatic bit hits(input logic [3:0] s, input int ch);
        return (s == 4'(ch)) || (s == 4'hF);
    endfunction

    task automatic m_exec(input logic [7:0] c, input logic [7:0] h, input logic [7:0] l);
        logic [15:0] w;
        w = {h, l};
        for (int ch = 0; ch < 2; ch++) begin
            if (hits(c[3:0], ch)) begin
                if (c[7:4] == 4'h8) m_code[ch] = w[15:4];
                if (c[7:4] >= 4'h1 && c[7:4] <= 4'h3) m_dac[ch] = m_code[ch];
            end
        end
        if (c[7:4] == 4'h4) m_pd = l[1:0];
        if (c[7:4] == 4'h7) begin m_rf = l[1:0]; m_mode = l[2]; end
        m_armed = 1'b1;
        m_echo = {c, h, l};
    endtask

    function automatic logic [7:0] exp_byte(input int i);
        logic [15:0] w;
        int ch;
        ch = (m_cmd[3:0] == 4'h1) ? 1 : 0;
        if (m_armed) return (i < 3) ? m_echo[23 - 8*i -: 8] : 8'hFF;
        if (i > 1) return 8'hFF;
        case (m_cmd[7:4])
            4'h8:             w = {m_code[ch], 4'h0};
            4'h1, 4'h2, 4'h3: w = {m_dac[ch], 4'h0};
            4'h4:             w = {14'h0, m_pd};
            default:          w = {8'h00, 1'b0, 3'b011, 1'b0, m_mode, m_rf};
        endcase
        return (i == 0) ? w[15:8] : w[7:0];
    endfunction

    task automatic wr_full(input logic [7:0] c, input logic [7:0] h,
                           input logic [7:0] l, input bit stop);
        pulse_start(1'b0);
        put_byte(c); m_cmd = c; m_armed = 1'b0;
        put_byte(h); put_byte(l);
        m_exec(c, h, l);
        if (stop) pulse_stop();
    endtask

    task automatic wr_cmd(input logic [7:0] c);
        pulse_start(1'b0);
        put_byte(c); m_cmd = c; m_armed = 1'b0;
    endtask

    task automatic rd_seq(input string tag, input int n);
        logic [7:0] b;
        logic v;
        pulse_start(1'b1);
        for (int i = 0; i < n; i++) begin
            get_byte(b, v);
            chk(tag, b, exp_byte(i));
        end
        send_nack();
        pulse_stop();
    endtask

    task automatic chk_outs(input string tag);
        chk(tag, dac_a, m_dac[0]);
        chk(tag, dac_b, m_dac[1]);
        chk(tag, pwdn, m_pd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic v;
        logic [3:0] sels [4];
        logic [11:0] val;
        sels[0] = 4'h0; sels[1] = 4'h1; sels[2] = 4'hF; sels[3] = 4'h5;
        for (int ch = 0; ch < 2; ch++) begin m_code[ch] = '0; m_dac[ch] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and identification word before any write
        chk_outs("R1");
        rd_seq("R1", 3);

        // R2 / R4 code writes over all select classes, read back per select
        for (int k = 0; k < 3; k++) begin
            for (int s = 0; s < 4; s++) begin
                val = 12'((s * 977 + k * 1365 + 123));
                wr_full({4'h8, sels[s]}, val[11:4], {val[3:0], 4'hA}, 1'b1);
                chk_outs("R2");
                for (int r = 0; r < 4; r++) begin
                    wr_cmd({4'h8, sels[r]});
                    rd_seq("R4", 2);
                end
            end
        end

        // R3 / R4 loads with every load operation and select class
        for (int op = 1; op <= 3; op++) begin
            for (int s = 0; s < 4; s++) begin
                val = 12'(op * 311 + s * 59);
                wr_full(8'h8F, val[11:4], {val[3:0], 4'h0}, 1'b1);
                wr_full({4'(op), sels[s]}, 8'h5A, 8'hC3, 1'b1);
                chk_outs("R3");
                for (int r = 0; r < 4; r++) begin
                    wr_cmd({4'(op), sels[r]});
                    rd_seq("R4", 2);
                end
            end
        end

        // R5 power patterns: outputs and modified readback
        for (int p = 0; p < 4; p++) begin
            wr_full(8'h40, 8'hFF, {6'b101010, 2'(p)}, 1'b1);
            chk_outs("R5");
            wr_cmd(8'h40);
            rd_seq("R5", 3);
        end

        // R6 reference settings, read back through every unsupported operation
        for (int rv = 0; rv < 8; rv++) begin
            wr_full(8'h70, 8'h00, 8'(rv), 1'b1);
            for (int op = 0; op < 16; op++) begin
                if (op == 8 || (op >= 1 && op <= 4)) continue;
                wr_cmd({4'(op), 4'h3});
                rd_seq("R6", 2);
            end
        end

        // R7 echo after STOP/START, after repeated START, and persistence
        wr_full(8'h81, 8'hA5, 8'h3C, 1'b1);
        rd_seq("R7", 4);
        rd_seq("R7", 3);
        wr_full(8'h2F, 8'h12, 8'h34, 1'b0);
        rd_seq("R7", 4);
        chk_outs("R7");

        // R8 writes cut short after one and two bytes
        wr_full(8'h80, 8'h11, 8'h20, 1'b1);
        pulse_start(1'b0); put_byte(8'h80); m_cmd = 8'h80; m_armed = 1'b0;
        put_byte(8'hEE);
        pulse_stop();
        rd_seq("R8", 2);
        wr_full(8'h81, 8'h22, 8'h30, 1'b1);
        wr_cmd(8'h81);
        rd_seq("R8", 3);

        // R10 extra write bytes are ignored
        pulse_start(1'b0);
        put_byte(8'h80); m_cmd = 8'h80; m_armed = 1'b0;
        put_byte(8'h9B); put_byte(8'h70);
        m_exec(8'h80, 8'h9B, 8'h70);
        put_byte(8'h01); put_byte(8'hFE);
        pulse_stop();
        rd_seq("R10", 4);
        wr_cmd(8'h80);
        rd_seq("R10", 2);

        // R9 reads after a NACK return all ones
        wr_cmd(8'h80);
        pulse_start(1'b1);
        get_byte(b, v);
        chk("R9", b, exp_byte(0));
        send_nack();
        get_byte(b, v);
        chk("R9", b, 8'hFF);
        get_byte(b, v);
        chk("R9", b, 8'hFF);
        pulse_stop();

        // R11 valid pulse timing
        pulse_start(1'b1);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        chk("R11", rd_valid, 1);
        @(negedge clk);
        chk("R11", rd_valid, 0);
        pulse_stop();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule